// File: doc/BRIEF.md
# Parallel SCSI Host Register and Bus-Line Unit

This block is the host-facing register file of an 8-bit parallel SCSI protocol controller. The host sees eight byte-wide addresses. Several of them select one register on a write and a different one on a read. Register bits drive the bus control lines and the data byte. The live bus lines come back through a synchronizer. From them the block builds status bytes, a phase-match flag and a set of latched interrupt conditions that are combined onto one IRQ line.

Arbitration timing and DMA data movement sit outside the block. It receives their status on plain inputs: arbitration in progress, arbitration lost, DRQ, end of transfer and last byte sent. It reflects those inputs in its registers. It also hands the start-arbitration bit to the arbitration engine.

Top module: `scsi_ctl_regs`

## Requirements
- R1: After reset every writable register is zero, every bus output and its data enable are low, and irq is low.
- R2: A write to address 0 loads the output data byte. A read of address 0 returns the synchronized bus data lines, not the written byte.
- R3: bus_data_out always carries the output data byte. bus_data_oe is high when the tri-state bit is clear and either arbitration is in progress or ICR bit 0 (assert data) is set while phase match holds.
- R4: The initiator command register is address 1. Bit 7 drives RST, bit 4 ACK, bit 3 BSY, bit 2 SEL, bit 1 ATN and bit 0 asserts data. Bit 6 written as 1 forces all bus outputs and the data enable low. A write to bit 5 is ignored. On a read, bit 6 returns arbitration in progress and bit 5 returns arbitration lost. ACK is driven only while target mode is off.
- R5: The mode register is address 2 and reads back as written. Bit 6 is target mode, bit 5 parity check, bit 4 parity interrupt enable, bit 3 end-of-transfer interrupt enable, bit 2 busy monitor and bit 0 start arbitration. Bit 0 appears on arb_start. Writes to addresses 5, 6 and 7 change no register.
- R6: The target command register is address 3. Bits 3..0 drive REQ, MSG, C/D and I/O, and only while target mode is on. A read returns last_byte_sent in bit 7, zeros in bits 6..4, and the stored bits 3..0.
- R7: A read of address 4 returns the synchronized lines, from bit 7 down: RST, BSY, REQ, MSG, C/D, I/O, SEL, parity. A write to address 4 loads the selection ID mask.
- R8: A read of address 5 returns, from bit 7 down: end-of-transfer flag, DRQ, parity error, irq, phase match, busy error, ATN, ACK. Phase match is 1 when the synchronized {MSG,C/D,I/O} equals target command bits 2..0.
- R9: The selection flag latches, and raises irq, when the synchronized lines show BSY low, SEL high and a data bit that is also set in the selection mask.
- R10: The data strobe is REQ in initiator mode and ACK in target mode. When parity check is on, a rising edge of the synchronized strobe with an even number of ones across the data and parity lines latches parity error. Parity error raises irq only with parity interrupt enable set.
- R11: A falling edge of the synchronized BSY while busy monitor is on latches busy error, which raises irq.
- R12: A rising edge of dma_end latches the end-of-transfer flag. That flag raises irq only with end-of-transfer interrupt enable set.
- R13: A read strobe at address 7 clears all latched flags. irq drops on the next cycle unless a new condition arrives in the same cycle.
- R14: Address 6 reads the input data latch, which captures the synchronized data lines on a falling edge of the synchronized strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe; side effect only at address 7 |
| host_rdata | output | 8 | Read data, combinational from host_addr |
| irq | output | 1 | Interrupt request |
| arb_start | output | 1 | Start-arbitration request to the arbitration engine |
| arb_in_prog | input | 1 | Arbitration in progress, from the arbitration engine |
| arb_lost | input | 1 | Arbitration lost, from the arbitration engine |
| dma_drq | input | 1 | DRQ level from the DMA engine |
| dma_end | input | 1 | End-of-transfer level from the DMA engine |
| last_byte_sent | input | 1 | Last-byte-sent flag from the DMA engine |
| bus_data_in | input | 8 | Bus data lines, 1 = active |
| bus_dbp_in | input | 1 | Bus parity line |
| bus_rst_in | input | 1 | Bus RST line |
| bus_bsy_in | input | 1 | Bus BSY line |
| bus_sel_in | input | 1 | Bus SEL line |
| bus_atn_in | input | 1 | Bus ATN line |
| bus_ack_in | input | 1 | Bus ACK line |
| bus_req_in | input | 1 | Bus REQ line |
| bus_msg_in | input | 1 | Bus MSG line |
| bus_cd_in | input | 1 | Bus C/D line |
| bus_io_in | input | 1 | Bus I/O line |
| bus_data_out | output | 8 | Data byte to drive |
| bus_data_oe | output | 1 | Data drive enable |
| bus_rst_out | output | 1 | Assert RST |
| bus_bsy_out | output | 1 | Assert BSY |
| bus_sel_out | output | 1 | Assert SEL |
| bus_atn_out | output | 1 | Assert ATN |
| bus_ack_out | output | 1 | Assert ACK |
| bus_req_out | output | 1 | Assert REQ |
| bus_msg_out | output | 1 | Assert MSG |
| bus_cd_out | output | 1 | Assert C/D |
| bus_io_out | output | 1 | Assert I/O |

## Verification
The assertions assume two things about the inputs. The host raises host_wr and host_rd for single clock cycles at a stable address. dma_end and the arbitration inputs are already synchronous. The edge-based properties also assume that target mode does not change while REQ or ACK is active, because switching the strobe source would otherwise look like an edge. The stimulus moves REQ, ACK and BSY only while the mode is settled. It holds every bus level for at least four cycles, so each change passes the synchronizer before any check.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;
  localparam int DW = 8;

  // register addresses
  localparam logic [2:0] A_DATA   = 3'd0;
  localparam logic [2:0] A_ICR    = 3'd1;
  localparam logic [2:0] A_MODE   = 3'd2;
  localparam logic [2:0] A_TCR    = 3'd3;
  localparam logic [2:0] A_STAT   = 3'd4;
  localparam logic [2:0] A_BSR    = 3'd5;
  localparam logic [2:0] A_INDATA = 3'd6;
  localparam logic [2:0] A_CLR    = 3'd7;

  // latched interrupt sources
  localparam int NSRC    = 4;
  localparam int SRC_SEL = 0;
  localparam int SRC_PAR = 1;
  localparam int SRC_BSY = 2;
  localparam int SRC_EOP = 3;

  typedef enum logic [2:0] {
    PH_DOUT = 3'd0, PH_DIN = 3'd1, PH_CMD = 3'd2,
    PH_STAT = 3'd3, PH_MOUT = 3'd6, PH_MIN = 3'd7
  } phase_e;

  typedef struct packed {
    logic          rst;
    logic          bsy;
    logic          sel;
    logic          atn;
    logic          ack;
    logic          req;
    logic          msg;
    logic          cd;
    logic          io;
    logic          dbp;
    logic [DW-1:0] data;
  } bus_lines_t;

  // phase code in target-command bit order
  function automatic logic [2:0] phase_of(bus_lines_t b);
    return {b.msg, b.cd, b.io};
  endfunction

  // odd parity across data and parity line is good
  function automatic logic parity_good(logic [DW-1:0] d, logic p);
    return ^{d, p};
  endfunction

  function automatic logic [7:0] status_byte(bus_lines_t b);
    return {b.rst, b.bsy, b.req, b.msg, b.cd, b.io, b.sel, b.dbp};
  endfunction
endpackage

// File: rtl/scsi_line_sync.sv
module scsi_line_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scsi_host_regs.sv
module scsi_host_regs
  import scsi_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr,
  input  logic          rd,
  input  bus_lines_t    bs,
  input  logic          arb_in_prog,
  input  logic          arb_lost,
  input  logic          dma_drq,
  input  logic          last_byte_sent,
  input  logic          end_f,
  input  logic          par_f,
  input  logic          bsy_f,
  input  logic          irq,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] odr_q,
  output logic [DW-1:0] sel_mask_q,
  output logic [3:0]    tcr_q,
  output logic          icr_rst,
  output logic          icr_tri,
  output logic          icr_ack,
  output logic          icr_bsy,
  output logic          icr_sel,
  output logic          icr_atn,
  output logic          icr_data,
  output logic          mode_target,
  output logic          mode_pchk,
  output logic          mode_pint,
  output logic          mode_eopint,
  output logic          mode_bsymon,
  output logic          mode_arb,
  output logic          phase_match,
  output logic          strobe_rise,
  output logic          rd_clear
);
  // icr7_q: [6]=rst [5]=tri-state [4]=ack [3]=bsy [2]=sel [1]=atn [0]=data
  logic [6:0]    icr7_q;
  logic [DW-1:0] mode_q;
  logic [DW-1:0] indata_q;
  logic          strobe_s, strobe_q, strobe_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odr_q      <= '0;
      icr7_q     <= '0;
      mode_q     <= '0;
      tcr_q      <= '0;
      sel_mask_q <= '0;
    end else if (wr) begin
      case (addr)
        A_DATA: odr_q      <= wdata;
        A_ICR:  icr7_q     <= {wdata[7:6], wdata[4:0]};
        A_MODE: mode_q     <= wdata;
        A_TCR:  tcr_q      <= wdata[3:0];
        A_STAT: sel_mask_q <= wdata;
        default: ;
      endcase
    end
  end

  assign {icr_rst, icr_tri, icr_ack, icr_bsy, icr_sel, icr_atn, icr_data} = icr7_q;
  assign mode_target = mode_q[6];
  assign mode_pchk   = mode_q[5];
  assign mode_pint   = mode_q[4];
  assign mode_eopint = mode_q[3];
  assign mode_bsymon = mode_q[2];
  assign mode_arb    = mode_q[0];

  assign phase_match = (phase_of(bs) == tcr_q[2:0]);

  // data strobe and its edges
  assign strobe_s = mode_target ? bs.ack : bs.req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_s;
  end

  assign strobe_rise = strobe_s & ~strobe_q;
  assign strobe_fall = ~strobe_s & strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           indata_q <= '0;
    else if (strobe_fall) indata_q <= bs.data;
  end

  assign rd_clear = rd && (addr == A_CLR);

  always_comb begin
    case (addr)
      A_DATA:   rdata = bs.data;
      A_ICR:    rdata = {icr7_q[6], arb_in_prog, arb_lost, icr7_q[4:0]};
      A_MODE:   rdata = mode_q;
      A_TCR:    rdata = {last_byte_sent, 3'b000, tcr_q};
      A_STAT:   rdata = status_byte(bs);
      A_BSR:    rdata = {end_f, dma_drq, par_f, irq, phase_match, bsy_f, bs.atn, bs.ack};
      A_INDATA: rdata = indata_q;
      default:  rdata = '0;
    endcase
  end

  AST_MODE_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_MODE) |=> ({mode_target, mode_pchk, mode_pint, mode_eopint, mode_bsymon, mode_arb}
                               == {$past(wdata[6]), $past(wdata[5:2]), $past(wdata[0])})); // R5
  AST_TCR_IGNORES_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == A_TCR) |=> $stable(tcr_q)); // R6
endmodule

// File: rtl/scsi_irq_latch.sv
module scsi_irq_latch
  import scsi_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  bus_lines_t    bs,
  input  logic [DW-1:0] sel_mask,
  input  logic          mode_pchk,
  input  logic          mode_pint,
  input  logic          mode_eopint,
  input  logic          mode_bsymon,
  input  logic          strobe_rise,
  input  logic          dma_end,
  input  logic          clr,
  output logic [NSRC-1:0] flags,
  output logic          irq
);
  logic [NSRC-1:0] set_v, en_v, flag_q;
  logic            bsy_q, end_q;
  logic            sel_hit, par_bad, bsy_drop, end_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy_q <= 1'b0;
      end_q <= 1'b0;
    end else begin
      bsy_q <= bs.bsy;
      end_q <= dma_end;
    end
  end

  assign sel_hit  = ~bs.bsy & bs.sel & (|(bs.data & sel_mask));
  assign par_bad  = mode_pchk & strobe_rise & ~parity_good(bs.data, bs.dbp);
  assign bsy_drop = mode_bsymon & bsy_q & ~bs.bsy;
  assign end_rise = dma_end & ~end_q;

  always_comb begin
    set_v          = '0;
    set_v[SRC_SEL] = sel_hit;
    set_v[SRC_PAR] = par_bad;
    set_v[SRC_BSY] = bsy_drop;
    set_v[SRC_EOP] = end_rise;
    en_v           = '1;
    en_v[SRC_PAR]  = mode_pint;
    en_v[SRC_EOP]  = mode_eopint;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= set_v | (flag_q & ~{NSRC{clr}});
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & en_v);

  AST_SEL_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[SRC_SEL]) |-> $past(|(bs.data & sel_mask)) && !$past(bs.bsy)); // R9
  AST_PAR_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[SRC_PAR]) |-> $past(mode_pchk)); // R10
  AST_BSY_ERR_NEEDS_MON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[SRC_BSY]) |-> $past(mode_bsymon)); // R11
  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_v == '0) |=> !irq); // R13
endmodule

// File: rtl/scsi_bus_drive.sv
module scsi_bus_drive
  import scsi_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] odr,
  input  logic [3:0]    tcr,
  input  logic          icr_rst,
  input  logic          icr_tri,
  input  logic          icr_ack,
  input  logic          icr_bsy,
  input  logic          icr_sel,
  input  logic          icr_atn,
  input  logic          icr_data,
  input  logic          mode_target,
  input  logic          arb_in_prog,
  input  logic          phase_match,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          rst_out,
  output logic          bsy_out,
  output logic          sel_out,
  output logic          atn_out,
  output logic          ack_out,
  output logic          req_out,
  output logic          msg_out,
  output logic          cd_out,
  output logic          io_out
);
  logic live;
  assign live = ~icr_tri;

  assign data_out = odr;
  assign data_oe  = live & (arb_in_prog | (icr_data & phase_match));
  assign rst_out  = live & icr_rst;
  assign bsy_out  = live & icr_bsy;
  assign sel_out  = live & icr_sel;
  assign atn_out  = live & icr_atn;
  assign ack_out  = live & icr_ack & ~mode_target;
  assign req_out  = live & mode_target & tcr[3];
  assign msg_out  = live & mode_target & tcr[2];
  assign cd_out   = live & mode_target & tcr[1];
  assign io_out   = live & mode_target & tcr[0];

  AST_TRI_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    icr_tri |-> !(data_oe | rst_out | bsy_out | sel_out | atn_out | ack_out
                  | req_out | msg_out | cd_out | io_out)); // R4
  AST_TGT_LINES_INIT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_target |-> !(req_out | msg_out | cd_out | io_out)); // R6
  AST_OE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (arb_in_prog || phase_match)); // R3
endmodule

// File: rtl/scsi_ctl_regs.sv
module scsi_ctl_regs
  import scsi_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    host_addr,
  input  logic [7:0]    host_wdata,
  input  logic          host_wr,
  input  logic          host_rd,
  output logic [7:0]    host_rdata,
  output logic          irq,
  output logic          arb_start,
  input  logic          arb_in_prog,
  input  logic          arb_lost,
  input  logic          dma_drq,
  input  logic          dma_end,
  input  logic          last_byte_sent,
  input  logic [7:0]    bus_data_in,
  input  logic          bus_dbp_in,
  input  logic          bus_rst_in,
  input  logic          bus_bsy_in,
  input  logic          bus_sel_in,
  input  logic          bus_atn_in,
  input  logic          bus_ack_in,
  input  logic          bus_req_in,
  input  logic          bus_msg_in,
  input  logic          bus_cd_in,
  input  logic          bus_io_in,
  output logic [7:0]    bus_data_out,
  output logic          bus_data_oe,
  output logic          bus_rst_out,
  output logic          bus_bsy_out,
  output logic          bus_sel_out,
  output logic          bus_atn_out,
  output logic          bus_ack_out,
  output logic          bus_req_out,
  output logic          bus_msg_out,
  output logic          bus_cd_out,
  output logic          bus_io_out
);
  localparam int LINES_W = $bits(bus_lines_t);

  bus_lines_t      bus_raw, bus_s;
  logic [DW-1:0]   odr_q, sel_mask_q;
  logic [3:0]      tcr_q;
  logic            icr_rst, icr_tri, icr_ack, icr_bsy, icr_sel, icr_atn, icr_data;
  logic            mode_target, mode_pchk, mode_pint, mode_eopint, mode_bsymon, mode_arb;
  logic            phase_match, strobe_rise, rd_clear;
  logic [NSRC-1:0] flags;

  assign bus_raw = '{rst: bus_rst_in, bsy: bus_bsy_in, sel: bus_sel_in, atn: bus_atn_in,
                     ack: bus_ack_in, req: bus_req_in, msg: bus_msg_in, cd: bus_cd_in,
                     io: bus_io_in, dbp: bus_dbp_in, data: bus_data_in};

  scsi_line_sync #(.W(LINES_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  scsi_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(host_addr), .wdata(host_wdata),
    .wr(host_wr), .rd(host_rd), .bs(bus_s),
    .arb_in_prog(arb_in_prog), .arb_lost(arb_lost), .dma_drq(dma_drq),
    .last_byte_sent(last_byte_sent),
    .end_f(flags[SRC_EOP]), .par_f(flags[SRC_PAR]), .bsy_f(flags[SRC_BSY]), .irq(irq),
    .rdata(host_rdata), .odr_q(odr_q), .sel_mask_q(sel_mask_q), .tcr_q(tcr_q),
    .icr_rst(icr_rst), .icr_tri(icr_tri), .icr_ack(icr_ack), .icr_bsy(icr_bsy),
    .icr_sel(icr_sel), .icr_atn(icr_atn), .icr_data(icr_data),
    .mode_target(mode_target), .mode_pchk(mode_pchk), .mode_pint(mode_pint),
    .mode_eopint(mode_eopint), .mode_bsymon(mode_bsymon), .mode_arb(mode_arb),
    .phase_match(phase_match), .strobe_rise(strobe_rise), .rd_clear(rd_clear)
  );

  scsi_irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .bs(bus_s), .sel_mask(sel_mask_q),
    .mode_pchk(mode_pchk), .mode_pint(mode_pint), .mode_eopint(mode_eopint),
    .mode_bsymon(mode_bsymon), .strobe_rise(strobe_rise), .dma_end(dma_end),
    .clr(rd_clear), .flags(flags), .irq(irq)
  );

  scsi_bus_drive u_drive (
    .clk(clk), .rst_n(rst_n), .odr(odr_q), .tcr(tcr_q),
    .icr_rst(icr_rst), .icr_tri(icr_tri), .icr_ack(icr_ack), .icr_bsy(icr_bsy),
    .icr_sel(icr_sel), .icr_atn(icr_atn), .icr_data(icr_data),
    .mode_target(mode_target), .arb_in_prog(arb_in_prog), .phase_match(phase_match),
    .data_out(bus_data_out), .data_oe(bus_data_oe), .rst_out(bus_rst_out),
    .bsy_out(bus_bsy_out), .sel_out(bus_sel_out), .atn_out(bus_atn_out),
    .ack_out(bus_ack_out), .req_out(bus_req_out), .msg_out(bus_msg_out),
    .cd_out(bus_cd_out), .io_out(bus_io_out)
  );

  assign arb_start = mode_arb;

  AST_IRQ_LOW_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !irq); // R1
endmodule

// File: tb/scsi_ctl_regs_bench.sv
`timescale 1ns/1ps
module scsi_ctl_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic irq, arb_start;
  logic arb_in_prog = 1'b0, arb_lost = 1'b0, dma_drq = 1'b0, dma_end = 1'b0, last_byte_sent = 1'b0;
  logic [7:0] bus_data_in = '0;
  logic bus_dbp_in = 0, bus_rst_in = 0, bus_bsy_in = 0, bus_sel_in = 0, bus_atn_in = 0;
  logic bus_ack_in = 0, bus_req_in = 0, bus_msg_in = 0, bus_cd_in = 0, bus_io_in = 0;
  logic [7:0] bus_data_out;
  logic bus_data_oe, bus_rst_out, bus_bsy_out, bus_sel_out, bus_atn_out, bus_ack_out;
  logic bus_req_out, bus_msg_out, bus_cd_out, bus_io_out;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scsi_ctl_regs u_scsi_ctl_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata), .irq(irq),
    .arb_start(arb_start), .arb_in_prog(arb_in_prog), .arb_lost(arb_lost),
    .dma_drq(dma_drq), .dma_end(dma_end), .last_byte_sent(last_byte_sent),
    .bus_data_in(bus_data_in), .bus_dbp_in(bus_dbp_in), .bus_rst_in(bus_rst_in),
    .bus_bsy_in(bus_bsy_in), .bus_sel_in(bus_sel_in), .bus_atn_in(bus_atn_in),
    .bus_ack_in(bus_ack_in), .bus_req_in(bus_req_in), .bus_msg_in(bus_msg_in),
    .bus_cd_in(bus_cd_in), .bus_io_in(bus_io_in),
    .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe), .bus_rst_out(bus_rst_out),
    .bus_bsy_out(bus_bsy_out), .bus_sel_out(bus_sel_out), .bus_atn_out(bus_atn_out),
    .bus_ack_out(bus_ack_out), .bus_req_out(bus_req_out), .bus_msg_out(bus_msg_out),
    .bus_cd_out(bus_cd_out), .bus_io_out(bus_io_out)
  );

  typedef struct packed {
    logic [2:0] wa;
    logic [7:0] wd;
    logic [2:0] ra;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{3'd2, 8'h5A, 3'd2, 8'h5A, 4'd5},  // R5 mode read-back
    '{3'd3, 8'hFF, 3'd3, 8'h0F, 4'd6},  // R6 only bits 3..0 kept
    '{3'd1, 8'h9F, 3'd1, 8'h9F, 4'd4},  // R4 command read-back
    '{3'd1, 8'h60, 3'd1, 8'h00, 4'd4},  // R4 bits 6,5 not read back
    '{3'd0, 8'hC3, 3'd0, 8'h00, 4'd2},  // R2 read shows bus, not written byte
    '{3'd4, 8'hFF, 3'd4, 8'h00, 4'd7},  // R7 write sets mask, read shows lines
    '{3'd5, 8'hFF, 3'd2, 8'h5A, 4'd5}   // R5 write to 5 changes nothing
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rdv(input logic [2:0] a, output logic [7:0] v);
    host_addr = a; #1; v = host_rdata;
  endtask

  task automatic clear_flags();
    host_addr = 3'd7; host_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {bus_rst_out, bus_bsy_out, bus_sel_out, bus_atn_out,
            bus_ack_out, bus_req_out, bus_msg_out, bus_cd_out};
  endfunction

  initial begin
    logic [7:0] v;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 outputs", outs(), 8'h00);
    chk("R1 oe/io", {6'd0, bus_data_oe, bus_io_out}, 8'h00);
    rdv(3'd2, v); chk("R1 mode", v, 8'h00);
    rdv(3'd1, v); chk("R1 icr", v, 8'h00);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      rdv(VECS[i].ra, v);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
    end
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h00); wr(3'd4, 8'h00);

    // R2 address 0 read returns synchronized bus data
    bus_data_in = 8'hA5; wait_cyc(3);
    rdv(3'd0, v); chk("R2 bus data", v, 8'hA5);
    bus_data_in = 8'h00; wait_cyc(3);

    // R3 data drive enable
    wr(3'd0, 8'h3C); wr(3'd1, 8'h01);
    chk("R3 oe on match", {bus_data_oe, 7'd0} | 8'(0), 8'h80);
    chk("R3 data out", bus_data_out, 8'h3C);
    wr(3'd3, 8'h01);
    chk("R3 oe on mismatch", {7'd0, bus_data_oe}, 8'h00);
    arb_in_prog = 1'b1; #1;
    chk("R3 oe in arbitration", {7'd0, bus_data_oe}, 8'h01);
    wr(3'd1, 8'h41);
    chk("R3 oe tri-stated", {7'd0, bus_data_oe}, 8'h00);
    arb_in_prog = 1'b0; wr(3'd1, 8'h00); wr(3'd3, 8'h00);

    // R4 command bits, dual-use read bits, ack in target mode, tri-state
    wr(3'd1, 8'h9E);
    chk("R4 initiator lines", outs(), 8'hF8);
    arb_in_prog = 1'b1; arb_lost = 1'b1;
    rdv(3'd1, v); chk("R4 arb flags read", v, 8'hFE);
    arb_in_prog = 1'b0; arb_lost = 1'b0;
    wr(3'd2, 8'h40);
    chk("R4 ack off in target", outs(), 8'hF0);
    wr(3'd2, 8'h00); wr(3'd1, 8'hDE);
    chk("R4 tri-state quiet", {outs()[7:1], bus_data_oe}, 8'h00);
    wr(3'd1, 8'h00);

    // R5 start-arbitration output
    wr(3'd2, 8'h01);
    chk("R5 arb_start high", {7'd0, arb_start}, 8'h01);
    wr(3'd2, 8'h00);
    chk("R5 arb_start low", {7'd0, arb_start}, 8'h00);

    // R6 target-only lines and last-byte flag
    wr(3'd2, 8'h40); wr(3'd3, 8'h0F);
    chk("R6 target lines", {bus_req_out, bus_msg_out, bus_cd_out, bus_io_out, 4'd0}, 8'hF0);
    last_byte_sent = 1'b1;
    rdv(3'd3, v); chk("R6 last byte", v, 8'h8F);
    wr(3'd2, 8'h00);
    chk("R6 lines off in initiator", {bus_req_out, bus_msg_out, bus_cd_out, bus_io_out, 4'd0}, 8'h00);
    last_byte_sent = 1'b0; wr(3'd3, 8'h00);

    // R7 status byte
    bus_rst_in = 1; bus_req_in = 1; bus_io_in = 1; bus_dbp_in = 1; wait_cyc(4);
    rdv(3'd4, v); chk("R7 status", v, 8'hA5);
    bus_rst_in = 0; bus_req_in = 0; bus_io_in = 0; bus_dbp_in = 0; wait_cyc(4);

    // R8 phase match and mirrors
    wr(3'd3, 8'h03);
    bus_cd_in = 1; bus_io_in = 1; bus_atn_in = 1; dma_drq = 1; wait_cyc(4);
    rdv(3'd5, v); chk("R8 phase match", v & 8'h4B, 8'h4A);
    bus_msg_in = 1; wait_cyc(4);
    rdv(3'd5, v); chk("R8 phase mismatch", v & 8'h4B, 8'h42);
    bus_msg_in = 0; bus_cd_in = 0; bus_io_in = 0; bus_atn_in = 0; dma_drq = 0;
    wr(3'd3, 8'h00); wait_cyc(4);

    // R9 selection interrupt
    wr(3'd4, 8'h04);
    bus_sel_in = 1; bus_data_in = 8'h02; wait_cyc(5);
    chk("R9 unmasked id ignored", {7'd0, irq}, 8'h00);
    bus_bsy_in = 1; bus_data_in = 8'h04; wait_cyc(5);
    chk("R9 bsy blocks select", {7'd0, irq}, 8'h00);
    bus_bsy_in = 0; wait_cyc(5);
    chk("R9 select irq", {7'd0, irq}, 8'h01);
    rdv(3'd5, v); chk("R9 irq mirror", v & 8'h10, 8'h10);
    bus_sel_in = 0; bus_data_in = 8'h00; wait_cyc(4);
    clear_flags(); #1;
    chk("R13 select cleared", {7'd0, irq}, 8'h00);
    wr(3'd4, 8'h00);

    // R10 parity
    wr(3'd2, 8'h30);
    bus_data_in = 8'h03; wait_cyc(4);
    bus_req_in = 1; wait_cyc(5);
    chk("R10 parity irq", {7'd0, irq}, 8'h01);
    rdv(3'd5, v); chk("R10 parity flag", v & 8'h20, 8'h20);
    bus_req_in = 0; wait_cyc(4);
    clear_flags(); #1;
    chk("R13 parity cleared", {7'd0, irq}, 8'h00);
    bus_data_in = 8'h01; wait_cyc(4);
    bus_req_in = 1; wait_cyc(5);
    chk("R10 good parity", {7'd0, irq}, 8'h00);
    bus_req_in = 0; wait_cyc(4);
    wr(3'd2, 8'h10);
    bus_data_in = 8'h03; wait_cyc(4);
    bus_req_in = 1; wait_cyc(5);
    rdv(3'd5, v); chk("R10 check disabled", v & 8'h30, 8'h00);
    bus_req_in = 0; bus_data_in = 8'h00; wait_cyc(4);
    wr(3'd2, 8'h00);

    // R11 busy error
    bus_bsy_in = 1; wait_cyc(4);
    bus_bsy_in = 0; wait_cyc(5);
    chk("R11 monitor off", {7'd0, irq}, 8'h00);
    wr(3'd2, 8'h04);
    bus_bsy_in = 1; wait_cyc(4);
    bus_bsy_in = 0; wait_cyc(5);
    chk("R11 busy irq", {7'd0, irq}, 8'h01);
    rdv(3'd5, v); chk("R11 busy flag", v & 8'h04, 8'h04);
    clear_flags(); #1;
    rdv(3'd5, v); chk("R13 busy cleared", v & 8'h14, 8'h00);
    wr(3'd2, 8'h00);

    // R12 end of transfer
    dma_end = 1; wait_cyc(2);
    rdv(3'd5, v); chk("R12 end flag, no irq", v & 8'h90, 8'h80);
    dma_end = 0; clear_flags();
    wr(3'd2, 8'h08);
    dma_end = 1; wait_cyc(2);
    chk("R12 end irq", {7'd0, irq}, 8'h01);
    dma_end = 0; clear_flags(); #1;
    rdv(3'd5, v); chk("R13 end cleared", v & 8'h90, 8'h00);
    wr(3'd2, 8'h00);

    // R14 input data latch on strobe fall
    bus_data_in = 8'h77; wait_cyc(4);
    bus_req_in = 1; wait_cyc(4);
    bus_data_in = 8'h5E; wait_cyc(4);
    bus_req_in = 0; wait_cyc(4);
    bus_data_in = 8'h99; wait_cyc(4);
    rdv(3'd6, v); chk("R14 input latch", v, 8'h5E);
    bus_data_in = 8'h00;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule